// File: doc/BRIEF.md
# Serial Flash Command Engine

This block sits on a simple word-wide register bus and runs exactly one serial-flash frame each time software launches it. A frame is a command byte, optionally followed by a three-byte flash address and up to four payload bytes, and may then continue with up to four bytes read back from the flash. Software fills the command/address register and the payload register, then writes the byte counts together with the launch bit in a single control write. Chip select is held low across the whole frame, the serial clock toggles in mode 0, and the busy flag stays set until the last bit has moved and chip select has returned high. The bytes that come back land in the payload register.

The serial clock period is a parameterised even number of system clocks. While a frame is in flight, the frame registers are frozen: bus writes to any of them are dropped, so software cannot disturb the bytes on the wire. Command sequencing, status polling and direct memory-mapped reads of the flash belong to other logic.

Top module: `spi_cmd_engine`

## Requirements
- R1: After synchronous reset every register reads zero, chip select is high, and the serial clock and serial data out are low.
- R2: The control register sits at byte offset 0x00, the command/address register at 0x04 and the payload register at 0x08. Control bits [3:0] hold the send count, bits [7:4] the receive count, bit 8 is the launch bit (reads back 0) and bit 16 is the read-only busy flag; the other two registers read back what was written.
- R3: The bytes sent are, in order: the command byte (command/address bits [7:0]); then, when the send count exceeds 1, the address bits [31:24], [23:16], [15:8]; then payload bits [7:0], [15:8], [23:16], [31:24]. The send count covers all of these bytes, and each byte leaves most significant bit first.
- R4: Received bytes are written into the payload register with the first received byte in bits [7:0], the second in [15:8], and so on; only the low bytes covered by the receive count are meaningful.
- R5: Mode 0 signalling: the serial clock rests low, serial data out is stable before each rising clock edge, serial data in is sampled on the rising edge, and chip select stays low for every clock pulse of the frame, including the receive bytes after the send bytes.
- R6: Busy reads 1 from the clock edge that accepts the launch and stays 1 for exactly 8 x (send bytes + receive bytes) x DIV system clocks; chip select rises on the same edge that busy falls.
- R7: A launch with a send count of 0 is ignored: busy stays 0 and chip select does not move.
- R8: A control write while busy, launch bit set or not, is discarded: no second frame starts and the stored counts are unchanged.
- R9: Writes to the command/address or payload register while busy are discarded, so the frame in flight and the readback after it are unaffected.
- R10: A send count above 8 is treated as 8 and a receive count above 4 is treated as 4.
- R11: The serial clock period is DIV system clocks, giving exactly 8 x (send + receive bytes) rising edges per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Assertions watch, on every cycle, that chip select is high whenever the engine is idle, that the serial clock rests low outside a frame, that busy only ever rises from an accepted launch carrying a nonzero send count, and that the command/address register cannot change while a frame runs. Only the bench scenarios can show the byte order on the wire, the placement of received bytes, the exact length of the busy window, the clamping of oversize counts and the discarding of writes during a frame, which it does by modelling a flash device that records the serial data out and replies with known bytes.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int REG_AW      = 4;
    localparam int MAX_TX      = 8;
    localparam int MAX_RX      = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
    localparam logic [REG_AW-1:0] OFS_CMD  = 4'h4;
    localparam logic [REG_AW-1:0] OFS_DATA = 4'h8;

    localparam int CTL_GO_BIT   = 8;
    localparam int CTL_BUSY_BIT = 16;

    typedef struct packed {
        logic [23:0] addr;
        logic [7:0]  cmd;
        logic [31:0] payload;
    } frame_t;

    function automatic logic [3:0] clamp_tx(input logic [3:0] n);
        return (n > 4'(MAX_TX)) ? 4'(MAX_TX) : n;
    endfunction

    function automatic logic [3:0] clamp_rx(input logic [3:0] n);
        return (n > 4'(MAX_RX)) ? 4'(MAX_RX) : n;
    endfunction

    // Byte that goes out in frame slot idx.
    function automatic logic [7:0] slot_byte(input frame_t f, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = f.cmd;
            4'd1:    b = f.addr[23:16];
            4'd2:    b = f.addr[15:8];
            4'd3:    b = f.addr[7:0];
            4'd4:    b = f.payload[7:0];
            4'd5:    b = f.payload[15:8];
            4'd6:    b = f.payload[23:16];
            4'd7:    b = f.payload[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    initial begin
        assert (DIV >= 2 && (DIV % 2) == 0)
            else $error("DIV must be even and at least 2");
    end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              busy_i,
    input  logic              rx_we_i,
    input  logic [1:0]        rx_idx_i,
    input  logic [7:0]        rx_byte_i,
    output frame_t            frame_o,
    output logic              start_o,
    output logic [3:0]        start_tx_o,
    output logic [3:0]        start_rx_o
);
    logic [3:0] tx_cnt_q, rx_cnt_q;
    frame_t     frame_q;

    logic wr_ok;
    assign wr_ok = wr_i && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_cnt_q <= '0;
            rx_cnt_q <= '0;
            frame_q  <= '0;
        end else begin
            if (wr_ok) begin
                case (addr_i)
                    OFS_CTRL: begin
                        tx_cnt_q <= wdata_i[3:0];
                        rx_cnt_q <= wdata_i[7:4];
                    end
                    OFS_CMD: begin
                        frame_q.cmd  <= wdata_i[7:0];
                        frame_q.addr <= wdata_i[31:8];
                    end
                    OFS_DATA: frame_q.payload <= wdata_i;
                    default: ;
                endcase
            end
            if (rx_we_i) begin
                frame_q.payload[rx_idx_i*8 +: 8] <= rx_byte_i;
            end
        end
    end

    assign start_o    = wr_ok && (addr_i == OFS_CTRL) && wdata_i[CTL_GO_BIT]
                        && (wdata_i[3:0] != 4'd0);
    assign start_tx_o = wdata_i[3:0];
    assign start_rx_o = wdata_i[7:4];
    assign frame_o    = frame_q;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_CTRL: begin
                rdata_o[3:0]         = tx_cnt_q;
                rdata_o[7:4]         = rx_cnt_q;
                rdata_o[CTL_BUSY_BIT] = busy_i;
            end
            OFS_CMD:  rdata_o = {frame_q.addr, frame_q.cmd};
            OFS_DATA: rdata_o = frame_q.payload;
            default:  rdata_o = '0;
        endcase
    end

    AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy_i && $past(busy_i)) |-> ($stable(frame_q.cmd) && $stable(frame_q.addr))) // R9
        else $error("command/address changed during a frame");
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [3:0] start_tx_i,
    input  logic [3:0] start_rx_i,
    input  frame_t     frame_i,
    input  logic       tick_i,
    input  logic       miso_i,
    output logic       busy_o,
    output logic       sclk_o,
    output logic       cs_n_o,
    output logic       mosi_o,
    output logic       rx_we_o,
    output logic [1:0] rx_idx_o,
    output logic [7:0] rx_byte_o
);
    logic       busy_q, sclk_q, cs_n_q;
    logic [2:0] bit_q;
    logic [3:0] slot_q, txe_q, rxe_q;
    logic [7:0] txsh_q, rxsh_q;

    logic [3:0] last_slot, rx_slot;
    logic       in_tx, rise, fall;

    assign last_slot = txe_q + rxe_q - 4'd1;
    assign in_tx     = slot_q < txe_q;
    assign rx_slot   = slot_q - txe_q;
    assign rise      = busy_q && tick_i && !sclk_q;
    assign fall      = busy_q && tick_i && sclk_q;

    assign rx_we_o   = rise && !in_tx && (bit_q == 3'd7);
    assign rx_idx_o  = rx_slot[1:0];
    assign rx_byte_o = {rxsh_q[6:0], miso_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
            bit_q  <= '0;
            slot_q <= '0;
            txe_q  <= '0;
            rxe_q  <= '0;
            txsh_q <= '0;
            rxsh_q <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cs_n_q <= 1'b0;
                sclk_q <= 1'b0;
                bit_q  <= '0;
                slot_q <= '0;
                txe_q  <= clamp_tx(start_tx_i);
                rxe_q  <= clamp_rx(start_rx_i);
                txsh_q <= slot_byte(frame_i, 4'd0);
            end
        end else if (rise) begin
            sclk_q <= 1'b1;
            rxsh_q <= {rxsh_q[6:0], miso_i};
        end else if (fall) begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
                if (slot_q == last_slot) begin
                    busy_q <= 1'b0;
                    cs_n_q <= 1'b1;
                end else begin
                    slot_q <= slot_q + 4'd1;
                    bit_q  <= '0;
                    txsh_q <= slot_byte(frame_i, slot_q + 4'd1);
                end
            end else begin
                bit_q  <= bit_q + 3'd1;
                txsh_q <= {txsh_q[6:0], 1'b0};
            end
        end
    end

    assign busy_o = busy_q;
    assign sclk_o = sclk_q;
    assign cs_n_o = cs_n_q;
    assign mosi_o = busy_q && in_tx && txsh_q[7];

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> cs_n_q) // R6
        else $error("chip select low while idle");

    AST_SCLK_REST_LOW: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> !sclk_q) // R5
        else $error("serial clock high outside a frame");

    AST_LAUNCH_NONZERO: assert property (@(posedge clk) disable iff (rst)
        start_i |-> (start_tx_i != 4'd0)) // R7
        else $error("launch accepted with zero send count");

    AST_BUSY_FROM_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(start_i)) // R8
        else $error("busy rose without an accepted launch");
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    frame_t     frame;
    logic       start, busy, tick, rx_we;
    logic [3:0] start_tx, start_rx;
    logic [1:0] rx_idx;
    logic [7:0] rx_byte;

    spi_cmd_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .rdata_o    (reg_rdata),
        .busy_i     (busy),
        .rx_we_i    (rx_we),
        .rx_idx_i   (rx_idx),
        .rx_byte_i  (rx_byte),
        .frame_o    (frame),
        .start_o    (start),
        .start_tx_o (start_tx),
        .start_rx_o (start_rx)
    );

    spi_cmd_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy),
        .tick_o (tick)
    );

    spi_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .start_tx_i (start_tx),
        .start_rx_i (start_rx),
        .frame_i    (frame),
        .tick_i     (tick),
        .miso_i     (miso),
        .busy_o     (busy),
        .sclk_o     (sclk),
        .cs_n_o     (cs_n),
        .mosi_o     (mosi),
        .rx_we_o    (rx_we),
        .rx_idx_o   (rx_idx),
        .rx_byte_o  (rx_byte)
    );
endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_cmd_engine #(.DIV(DIV)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Flash device model
    logic [7:0] rsp [16];
    logic [7:0] cap [16];
    int bitn = 0;
    int rise_cnt = 0;
    int cs_fall_cnt = 0;
    int sclk_no_cs = 0;

    always @(negedge cs_n) begin
        cs_fall_cnt++;
        bitn = 0;
        miso = rsp[0][7];
    end
    always @(posedge sclk) begin
        rise_cnt++;
        if (cs_n) sclk_no_cs++;
        if (bitn < 128) cap[bitn/8][7 - bitn%8] = mosi;
    end
    always @(negedge sclk) begin
        bitn++;
        if (bitn < 128) miso = rsp[bitn/8][7 - bitn%8];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] c, input logic [23:0] a,
                                            input logic [31:0] d, input int i);
        case (i)
            0: return c;
            1: return a[23:16];
            2: return a[15:8];
            3: return a[7:0];
            default: return d[(i-4)*8 +: 8];
        endcase
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 4'h0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        reg_addr = 4'h0;
        #1;
        while (reg_rdata[16] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic xfer(input logic [7:0] c, input logic [23:0] a, input logic [31:0] d,
                        input int tx, input int rx, input string req);
        int cyc, txe, rxe;
        logic [31:0] v;
        for (int i = 0; i < 16; i++) rsp[i] = 8'($urandom);
        wr(4'h4, {a, c});
        wr(4'h8, d);
        rise_cnt = 0;
        wr(4'h0, {23'd0, 1'b1, 4'(rx), 4'(tx)});
        txe = (tx > 8) ? 8 : tx;
        rxe = (rx > 4) ? 4 : rx;
        wait_idle(cyc);
        check(cyc == 8*(txe+rxe)*DIV, {"R6 busy length ", req}, cyc, 8*(txe+rxe)*DIV);
        check(rise_cnt == 8*(txe+rxe), {"R11 clock count ", req}, rise_cnt, 8*(txe+rxe));
        check(cs_n == 1'b1 && sclk == 1'b0, {"R5 idle lines ", req}, {cs_n, sclk}, 2'b10);
        for (int i = 0; i < txe; i++)
            check(cap[i] == exp_byte(c, a, d, i), {"R3 sent byte ", req}, cap[i], exp_byte(c, a, d, i));
        rd(4'h8, v);
        for (int j = 0; j < rxe; j++)
            check(v[j*8 +: 8] == rsp[txe+j], {"R4 received byte ", req}, v[j*8 +: 8], rsp[txe+j]);
        rd(4'h0, v);
        check(v == {24'd0, 4'(rx), 4'(tx)}, {"R2 control readback ", req}, v, {24'd0, 4'(rx), 4'(tx)});
    endtask

    initial begin
        logic [31:0] v;
        int cyc, falls;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) rsp[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check(v == 0, "R1 control after reset", v, 0);
        rd(4'h4, v); check(v == 0, "R1 command after reset", v, 0);
        rd(4'h8, v); check(v == 0, "R1 payload after reset", v, 0);
        check({cs_n, sclk, mosi} == 3'b100, "R1 lines after reset", {cs_n, sclk, mosi}, 3'b100);

        // R2 readback of written registers
        wr(4'h4, 32'hA1B2C3D4); rd(4'h4, v); check(v == 32'hA1B2C3D4, "R2 command readback", v, 32'hA1B2C3D4);
        wr(4'h8, 32'h0F1E2D3C); rd(4'h8, v); check(v == 32'h0F1E2D3C, "R2 payload readback", v, 32'h0F1E2D3C);

        // Directed frames
        xfer(8'h06, 24'h000000, 32'h0, 1, 0, "single command");
        xfer(8'hD8, 24'h12AB34, 32'h0, 4, 0, "address only");
        xfer(8'h02, 24'h0300FF, 32'h44332211, 8, 0, "program four bytes");
        xfer(8'h02, 24'h7E8001, 32'hCAFEBABE, 5, 0, "program one byte");
        xfer(8'hAB, 24'h000000, 32'h0, 4, 1, "signature read");
        xfer(8'h03, 24'h00F0F0, 32'hFFFFFFFF, 4, 4, "four byte read R5 receive phase");
        xfer(8'h05, 24'h0, 32'h0, 1, 2, "status read");
        xfer(8'h9F, 24'h55AA55, 32'h89ABCDEF, 12, 6, "R10 oversize counts");

        // R7 zero send count launch
        falls = cs_fall_cnt;
        wr(4'h0, {23'd0, 1'b1, 4'd3, 4'd0});
        repeat (10) @(negedge clk);
        rd(4'h0, v);
        check(v[16] == 1'b0, "R7 busy after zero-count launch", v[16], 0);
        check(cs_fall_cnt == falls && cs_n, "R7 chip select untouched", cs_fall_cnt - falls, 0);

        // R8 / R9 writes during a frame
        wr(4'h4, {24'h102030, 8'hD8});
        wr(4'h8, 32'h11223344);
        rise_cnt = 0;
        falls = cs_fall_cnt;
        wr(4'h0, {23'd0, 1'b1, 4'd0, 4'd4});
        wr(4'h4, 32'hDEADBEEF);
        wr(4'h8, 32'h55667788);
        wr(4'h0, {23'd0, 1'b1, 4'd2, 4'd1});
        wait_idle(cyc);
        repeat (20) @(negedge clk);
        check(rise_cnt == 32, "R8 single frame length", rise_cnt, 32);
        check(cs_fall_cnt == falls + 1, "R8 no second launch", cs_fall_cnt - falls, 1);
        check(cap[0] == 8'hD8 && cap[1] == 8'h10 && cap[3] == 8'h30, "R9 bytes on wire",
              {cap[0], cap[1], cap[3]}, 24'hD81030);
        rd(4'h4, v); check(v == {24'h102030, 8'hD8}, "R9 command readback", v, {24'h102030, 8'hD8});
        rd(4'h8, v); check(v == 32'h11223344, "R9 payload readback", v, 32'h11223344);
        rd(4'h0, v); check(v == 32'h04, "R8 control readback", v, 32'h04);

        // Random frames
        for (int k = 0; k < 25; k++) begin
            int tx, rx;
            tx = 1 + int'($urandom_range(0, 7));
            rx = int'($urandom_range(0, 4));
            xfer(8'($urandom), 24'($urandom), $urandom, tx, rx, "random");
        end

        check(sclk_no_cs == 0, "R5 clock pulse with chip select high", sclk_no_cs, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule